// File: doc/BRIEF.md
# Conversion Slot Priority Arbiter

This block chooses which of sixteen conversion slots gets the single shared converter next. Each slot holds its own configuration: a trigger selector, an analog channel number, a sample-window code and a 2-bit selector that ties the slot to one of two end-of-conversion interrupts. A slot becomes pending when the trigger it selects pulses, when software writes a force mask with that slot's bit set, or when the interrupt it selects pulses. Re-triggering from an interrupt lets one conversion start the next.

A single priority-mode value splits the slots into two groups. Slots below the mode value form a fixed-priority group in which the lower number wins. The remaining slots are serviced round robin. The chosen slot's channel and window code are sent to the converter with a one-cycle start pulse. The block then stays busy until the converter returns a done pulse. A power-enable input gates all grants.

Top module: `conv_slot_arbiter`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), busy and conv_start are 0, no slot is pending, and the first round-robin search begins at slot 0.
- R2: A cycle with force_we high sets pending for every slot whose force_mask bit is 1. Several slots can be forced in the same cycle.
- R3: A trigger-select value s from 1 to 7 makes a pulse on ext_trig[s-1] set that slot pending. Value 0 means software only. A pulse on a trigger that no slot selects has no effect.
- R4: Each slot's 2-bit interrupt selector decodes as follows: 0 means none, 1 means irq_a, 2 means irq_b and 3 means none. A pulse on the selected interrupt sets that slot pending.
- R5: A pending request that arrives for a slot that is already pending is absorbed, so the slot gives exactly one conversion.
- R6: With prio_mode 16 or above, every slot has fixed priority and the lowest pending slot number is granted first.
- R7: With prio_mode 0, every slot is round robin. The search starts at the slot after the last round-robin slot granted and wraps from 15 to 0.
- R8: With prio_mode k from 1 to 15, slots 0 to k-1 have fixed priority, with the lower number winning. Any pending slot in that group wins over every pending round-robin slot, including one that became pending later.
- R9: A grant is made at the rising edge after the request becomes pending. It raises conv_start for exactly one cycle and loads conv_slot, conv_chan and conv_win with the slot number, its channel and its stored window code (window length minus 1, for 1 to 512 cycles). These outputs hold until the next grant.
- R10: busy rises with conv_start and stays high until the edge at which conv_done is sampled. No grant is made while busy is high. A conv_done pulse while idle is ignored.
- R11: While pwr_en is 0, no grant is made and pending slots are kept. They are granted once pwr_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Converter power enable; grants only when 1 |
| prio_mode | input | 5 | Number of fixed-priority slots (0 = all round robin, 16+ = all fixed) |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot being configured |
| cfg_trig | input | 3 | Trigger select (0 = software only) |
| cfg_chan | input | 4 | Channel number |
| cfg_win | input | 9 | Sample window code (cycles minus 1) |
| cfg_isel | input | 2 | Interrupt re-trigger select |
| force_we | input | 1 | Software force strobe |
| force_mask | input | 16 | One bit per slot to force pending |
| ext_trig | input | 7 | External trigger pulses |
| irq_a | input | 1 | End-of-conversion interrupt A pulse |
| irq_b | input | 1 | End-of-conversion interrupt B pulse |
| conv_done | input | 1 | Converter done pulse |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_slot | output | 4 | Slot being converted |
| conv_chan | output | 4 | Channel for the conversion |
| conv_win | output | 9 | Window code for the conversion |
| busy | output | 1 | Conversion in progress |

## Verification
A request driven in one cycle becomes pending at the next rising edge. If the converter is idle and powered, conv_start and busy appear at the edge after that, which is two edges after the stimulus. A conv_done clears busy at the first edge, so the next grant can follow one edge later. The bench drives every input at a falling edge and samples the outputs at falling edges. A scenario waits for the conv_start falling-edge sample, then checks the slot and configuration outputs in that same sample. Ignored stimuli are checked by watching conv_start stay low over a window longer than the two-edge latency.

// File: rtl/conv_arb_pkg.sv
// Shared types for the conversion slot arbiter.
package conv_arb_pkg;

    // Interrupt re-trigger selector held per slot
    typedef enum logic [1:0] {
        IRQSEL_NONE = 2'd0,
        IRQSEL_A    = 2'd1,
        IRQSEL_B    = 2'd2,
        IRQSEL_RSVD = 2'd3
    } irq_sel_e;

endpackage

// File: rtl/slot_cfg_bank.sv
// Per-slot configuration storage and request decode.
// Each slot stores its trigger select, channel, window code and interrupt
// selector. The bank produces one request bit per slot from the external
// triggers, the software force strobe and the two interrupts. It also reads
// back the channel and window of one selected slot.
// Assumes trigger and interrupt inputs are single-cycle pulses in clk domain.
module slot_cfg_bank
    import conv_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int TSEL_W    = 3,
    parameter int CHAN_W    = 4,
    parameter int WIN_W     = 9,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int NUM_TRIG  = (1 << TSEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [TSEL_W-1:0]    cfg_trig,
    input  logic [CHAN_W-1:0]    cfg_chan,
    input  logic [WIN_W-1:0]     cfg_win,
    input  logic [1:0]           cfg_isel,
    input  logic                 force_we,
    input  logic [NUM_SLOTS-1:0] force_mask,
    input  logic [NUM_TRIG-1:0]  ext_trig,
    input  logic                 irq_a,
    input  logic                 irq_b,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [NUM_SLOTS-1:0] set_vec,
    output logic [CHAN_W-1:0]    rd_chan,
    output logic [WIN_W-1:0]     rd_win
);

    logic [NUM_SLOTS-1:0][CHAN_W-1:0] chan_arr;
    logic [NUM_SLOTS-1:0][WIN_W-1:0]  win_arr;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [TSEL_W-1:0] trig_q;
        logic [CHAN_W-1:0] chan_q;
        logic [WIN_W-1:0]  win_q;
        irq_sel_e          isel_q;
        logic              trig_hit;
        logic              irq_hit;

        // Hold this slot's configuration, loaded by an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trig_q <= '0;
                chan_q <= '0;
                win_q  <= '0;
                isel_q <= IRQSEL_NONE;
            end else if (cfg_we && (cfg_slot == SLOT_W'(s))) begin
                trig_q <= cfg_trig;
                chan_q <= cfg_chan;
                win_q  <= cfg_win;
                isel_q <= irq_sel_e'(cfg_isel);
            end
        end

        // Decode the selected external trigger; zero means software only
        always_comb begin
            trig_hit = 1'b0;
            if (trig_q != '0) begin
                trig_hit = ext_trig[trig_q - TSEL_W'(1)];
            end
        end

        // Decode the selected interrupt; the reserved code never fires
        always_comb begin
            unique case (isel_q)
                IRQSEL_A: irq_hit = irq_a;
                IRQSEL_B: irq_hit = irq_b;
                default:  irq_hit = 1'b0;
            endcase
        end

        assign set_vec[s]  = trig_hit | irq_hit | (force_we & force_mask[s]);
        assign chan_arr[s] = chan_q;
        assign win_arr[s]  = win_q;
    end

    assign rd_chan = chan_arr[rd_slot];
    assign rd_win  = win_arr[rd_slot];

endmodule

// File: rtl/slot_pend.sv
// Pending request register, one bit per slot.
// A new request ORs into the register, so a repeat for a slot that is
// already pending merges. A grant clears only the granted bit. A request
// that lands in the same cycle as that slot's grant re-arms it.
module slot_pend #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] set_vec,
    input  logic [NUM_SLOTS-1:0] clr_vec,
    output logic [NUM_SLOTS-1:0] pend
);

    // Accumulate requests and drop the slot just granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/slot_pick.sv
// Combinational winner selection among pending slots.
// Slots numbered below the mode value form the fixed group, where the lowest
// index wins. The others form the rotating group, searched from the slot
// after rr_last and wrapping. Any fixed-group request beats the rotating group.
// Assumes mode values above NUM_SLOTS behave like NUM_SLOTS.
module slot_pick #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int MODE_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_SLOTS-1:0] pend,
    input  logic [MODE_W-1:0]    mode,
    input  logic [SLOT_W-1:0]    rr_last,
    output logic                 any,
    output logic [SLOT_W-1:0]    pick_slot,
    output logic                 pick_rr
);

    logic [NUM_SLOTS-1:0] fix_mask;
    logic [NUM_SLOTS-1:0] fix_pend;
    logic [NUM_SLOTS-1:0] rot_pend;
    logic                 fix_any;
    logic                 rot_any;
    logic [SLOT_W-1:0]    fix_idx;
    logic [SLOT_W-1:0]    rot_idx;

    // Mark the slots that belong to the fixed-priority group
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            fix_mask[i] = (i < int'(mode));
        end
    end

    assign fix_pend = pend & fix_mask;
    assign rot_pend = pend & ~fix_mask;

    // Lowest pending slot in the fixed group
    always_comb begin
        fix_any = 1'b0;
        fix_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (fix_pend[i]) begin
                fix_any = 1'b1;
                fix_idx = SLOT_W'(i);
            end
        end
    end

    // First pending rotating slot after rr_last, with wrap-around
    always_comb begin
        rot_any = 1'b0;
        rot_idx = '0;
        for (int off = NUM_SLOTS; off >= 1; off--) begin
            int idx;
            idx = int'(rr_last) + off;
            if (idx >= NUM_SLOTS) begin
                idx = idx - NUM_SLOTS;
            end
            if (rot_pend[idx]) begin
                rot_any = 1'b1;
                rot_idx = SLOT_W'(idx);
            end
        end
    end

    // Fixed group wins outright over the rotating group
    always_comb begin
        any       = fix_any | rot_any;
        pick_rr   = !fix_any && rot_any;
        pick_slot = fix_any ? fix_idx : rot_idx;
    end

endmodule

// File: rtl/conv_issue.sv
// Grant and converter hand-off sequencer.
// This block grants the picked slot when powered, idle and something is
// pending. On a grant it registers the slot's channel and window code, pulses
// start for one cycle and holds busy until the done pulse. It also keeps the
// last rotating-group slot granted, which is the round-robin pointer.
// Assumes conv_done is a single-cycle pulse.
module conv_issue #(
    parameter int NUM_SLOTS = 16,
    parameter int CHAN_W    = 4,
    parameter int WIN_W     = 9,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_en,
    input  logic                 conv_done,
    input  logic                 any,
    input  logic [SLOT_W-1:0]    pick_slot,
    input  logic                 pick_rr,
    input  logic [CHAN_W-1:0]    rd_chan,
    input  logic [WIN_W-1:0]     rd_win,
    output logic [NUM_SLOTS-1:0] clr_vec,
    output logic [SLOT_W-1:0]    rr_last,
    output logic                 busy,
    output logic                 conv_start,
    output logic [SLOT_W-1:0]    conv_slot,
    output logic [CHAN_W-1:0]    conv_chan,
    output logic [WIN_W-1:0]     conv_win
);

    logic grant;

    assign grant   = pwr_en && !busy && any;
    assign clr_vec = grant ? (NUM_SLOTS'(1) << pick_slot) : '0;

    // Issue a grant, track busy and move the round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_slot  <= '0;
            conv_chan  <= '0;
            conv_win   <= '0;
            rr_last    <= SLOT_W'(NUM_SLOTS - 1);
        end else begin
            conv_start <= grant;
            if (grant) begin
                busy      <= 1'b1;
                conv_slot <= pick_slot;
                conv_chan <= rd_chan;
                conv_win  <= rd_win;
                if (pick_rr) begin
                    rr_last <= pick_slot;
                end
            end else if (busy && conv_done) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/conv_slot_arbiter.sv
// Top level of the conversion slot arbiter.
// It chains the configuration bank, the pending register, the picker and the
// issue sequencer. Requests take one edge to become pending and one more
// edge to be granted.
module conv_slot_arbiter #(
    parameter int NUM_SLOTS = 16,
    parameter int TSEL_W    = 3,
    parameter int CHAN_W    = 4,
    parameter int WIN_W     = 9,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int MODE_W    = $clog2(NUM_SLOTS + 1),
    parameter int NUM_TRIG  = (1 << TSEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_en,
    input  logic [MODE_W-1:0]    prio_mode,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [TSEL_W-1:0]    cfg_trig,
    input  logic [CHAN_W-1:0]    cfg_chan,
    input  logic [WIN_W-1:0]     cfg_win,
    input  logic [1:0]           cfg_isel,
    input  logic                 force_we,
    input  logic [NUM_SLOTS-1:0] force_mask,
    input  logic [NUM_TRIG-1:0]  ext_trig,
    input  logic                 irq_a,
    input  logic                 irq_b,
    input  logic                 conv_done,
    output logic                 conv_start,
    output logic [SLOT_W-1:0]    conv_slot,
    output logic [CHAN_W-1:0]    conv_chan,
    output logic [WIN_W-1:0]     conv_win,
    output logic                 busy
);

    logic [NUM_SLOTS-1:0] set_vec;
    logic [NUM_SLOTS-1:0] clr_vec;
    logic [NUM_SLOTS-1:0] pend;
    logic [SLOT_W-1:0]    rr_last;
    logic [SLOT_W-1:0]    pick_slot;
    logic                 pick_rr;
    logic                 any;
    logic [CHAN_W-1:0]    rd_chan;
    logic [WIN_W-1:0]     rd_win;

    slot_cfg_bank #(
        .NUM_SLOTS(NUM_SLOTS), .TSEL_W(TSEL_W), .CHAN_W(CHAN_W),
        .WIN_W(WIN_W), .SLOT_W(SLOT_W), .NUM_TRIG(NUM_TRIG)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_trig(cfg_trig),
        .cfg_chan(cfg_chan), .cfg_win(cfg_win), .cfg_isel(cfg_isel),
        .force_we(force_we), .force_mask(force_mask), .ext_trig(ext_trig),
        .irq_a(irq_a), .irq_b(irq_b), .rd_slot(pick_slot),
        .set_vec(set_vec), .rd_chan(rd_chan), .rd_win(rd_win)
    );

    slot_pend #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_vec(clr_vec), .pend(pend)
    );

    slot_pick #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .MODE_W(MODE_W)
    ) u_pick (
        .pend(pend), .mode(prio_mode), .rr_last(rr_last),
        .any(any), .pick_slot(pick_slot), .pick_rr(pick_rr)
    );

    conv_issue #(
        .NUM_SLOTS(NUM_SLOTS), .CHAN_W(CHAN_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .conv_done(conv_done),
        .any(any), .pick_slot(pick_slot), .pick_rr(pick_rr),
        .rd_chan(rd_chan), .rd_win(rd_win), .clr_vec(clr_vec),
        .rr_last(rr_last), .busy(busy), .conv_start(conv_start),
        .conv_slot(conv_slot), .conv_chan(conv_chan), .conv_win(conv_win)
    );

endmodule

// File: rtl/conv_slot_arbiter_chk.sv
// Protocol checker for the conversion slot arbiter, bound to the top.
// It watches the converter hand-off ports: start pulse shape, busy hold
// and release, output stability while busy, and power gating.
module conv_slot_arbiter_chk #(
    parameter int SLOT_W = 4,
    parameter int CHAN_W = 4,
    parameter int WIN_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_en,
    input logic              conv_done,
    input logic              conv_start,
    input logic              busy,
    input logic [SLOT_W-1:0] conv_slot,
    input logic [CHAN_W-1:0] conv_chan,
    input logic [WIN_W-1:0]  conv_win
);

    a_r9_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r10_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> busy);

    a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);

    a_r10_no_grant_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !conv_start);

    a_r9_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> ($stable(conv_slot) && $stable(conv_chan) && $stable(conv_win)));

    a_r11_no_grant_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !conv_start);

endmodule

bind conv_slot_arbiter conv_slot_arbiter_chk #(
    .SLOT_W(SLOT_W), .CHAN_W(CHAN_W), .WIN_W(WIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .conv_done(conv_done),
    .conv_start(conv_start), .busy(busy), .conv_slot(conv_slot),
    .conv_chan(conv_chan), .conv_win(conv_win)
);

// File: tb/tb_conv_slot_arbiter.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_conv_slot_arbiter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0;
    logic [4:0]  prio_mode = 5'd16;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_slot = '0;
    logic [2:0]  cfg_trig = '0;
    logic [3:0]  cfg_chan = '0;
    logic [8:0]  cfg_win = '0;
    logic [1:0]  cfg_isel = '0;
    logic        force_we = 1'b0;
    logic [15:0] force_mask = '0;
    logic [6:0]  ext_trig = '0;
    logic        irq_a = 1'b0;
    logic        irq_b = 1'b0;
    logic        conv_done = 1'b0;
    logic        conv_start;
    logic [3:0]  conv_slot;
    logic [3:0]  conv_chan;
    logic [8:0]  conv_win;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_slot_arbiter dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .prio_mode(prio_mode),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_trig(cfg_trig),
        .cfg_chan(cfg_chan), .cfg_win(cfg_win), .cfg_isel(cfg_isel),
        .force_we(force_we), .force_mask(force_mask), .ext_trig(ext_trig),
        .irq_a(irq_a), .irq_b(irq_b), .conv_done(conv_done),
        .conv_start(conv_start), .conv_slot(conv_slot), .conv_chan(conv_chan),
        .conv_win(conv_win), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic force_slots(input logic [15:0] mask);
        @(negedge clk);
        force_we = 1'b1; force_mask = mask;
        @(negedge clk);
        force_we = 1'b0; force_mask = '0;
    endtask

    task automatic write_cfg(input int s, input int trig, input int chan,
                             input int win, input int isel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 4'(s); cfg_trig = 3'(trig);
        cfg_chan = 4'(chan); cfg_win = 9'(win); cfg_isel = 2'(isel);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Wait for the next start, check its slot, then answer with done
    task automatic expect_next(input int exp, input logic [15:0] inj, input string tag);
        int  waited = 0;
        bit  seen = 0;
        while (!seen && waited < 60) begin
            @(negedge clk);
            waited++;
            if (conv_start) seen = 1;
        end
        if (!seen) begin
            check(1'b0, {tag, " no start"}, -1, exp);
        end else begin
            check(conv_slot == 4'(exp) && busy, tag, int'(conv_slot), exp);
            conv_done = 1'b1;
            if (inj != '0) begin
                force_we = 1'b1; force_mask = inj;
            end
            @(negedge clk);
            conv_done = 1'b0; force_we = 1'b0; force_mask = '0;
        end
    endtask

    // No start may appear for n cycles
    task automatic expect_idle(input int n, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) hits++;
        end
        check(hits == 0, tag, hits, 0);
    endtask

    task automatic t_reset;
        check(busy == 1'b0 && conv_start == 1'b0, "R1 reset outputs", int'(busy), 0);
        pwr_en = 1'b1;
        expect_idle(10, "R1 nothing pending after reset");
    endtask

    task automatic t_fixed;
        prio_mode = 5'd16;
        force_slots(16'h00A5);
        expect_next(0, '0, "R6/R2 fixed first");
        expect_next(2, '0, "R6 fixed second");
        expect_next(5, '0, "R6 fixed third");
        expect_next(7, '0, "R6 fixed fourth");
    endtask

    task automatic t_round_robin;
        prio_mode = 5'd0;
        force_slots(16'h1208);
        expect_next(3, '0, "R7/R1 rr starts at slot 0 search");
        expect_next(9, '0, "R7 rr second");
        expect_next(12, '0, "R7 rr third");
        force_slots(16'h2002);
        expect_next(13, '0, "R7 rr after last serviced");
        expect_next(1, '0, "R7 rr wraps");
    endtask

    task automatic t_split;
        prio_mode = 5'd4;
        force_slots(16'h0445);
        expect_next(0, '0, "R8 fixed group first");
        expect_next(2, '0, "R8 fixed group second");
        expect_next(6, 16'h0002, "R8 rr slot after fixed");
        expect_next(1, '0, "R8 late fixed beats pending rr");
        expect_next(10, '0, "R8 rr remaining");
    endtask

    task automatic t_trigger;
        prio_mode = 5'd16;
        write_cfg(5, 3, 9, 98, 0);
        @(negedge clk); ext_trig = 7'b0000100;
        @(negedge clk); ext_trig = '0;
        expect_next(5, '0, "R3 selected trigger");
        check(conv_chan == 4'd9, "R9 channel issued", int'(conv_chan), 9);
        check(conv_win == 9'd98, "R9 window code issued", int'(conv_win), 98);
        @(negedge clk); ext_trig = 7'b1111011;
        @(negedge clk); ext_trig = '0;
        expect_idle(10, "R3 unselected triggers ignored");
    endtask

    task automatic t_irq;
        write_cfg(8, 0, 1, 10, 1);
        write_cfg(9, 0, 2, 20, 2);
        write_cfg(10, 0, 3, 30, 3);
        @(negedge clk); irq_a = 1'b1;
        @(negedge clk); irq_a = 1'b0;
        expect_next(8, '0, "R4 irq_a retriggers slot 8");
        expect_idle(10, "R4 irq_a only one slot, code 3 none");
        @(negedge clk); irq_b = 1'b1;
        @(negedge clk); irq_b = 1'b0;
        expect_next(9, '0, "R4 irq_b retriggers slot 9");
        check(conv_win == 9'd20, "R4 slot 9 window", int'(conv_win), 20);
        expect_idle(10, "R4 irq_b only one slot");
    endtask

    task automatic t_absorb_power;
        pwr_en = 1'b0;
        force_slots(16'h0008);
        force_slots(16'h0008);
        expect_idle(10, "R11 no grant while unpowered");
        pwr_en = 1'b1;
        expect_next(3, '0, "R11 pending kept through power off");
        expect_idle(20, "R5 repeat request absorbed");
    endtask

    task automatic t_busy;
        int bad = 0;
        int waited = 0;
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check(busy == 1'b0, "R10 idle done ignored", int'(busy), 0);
        force_slots(16'h0011);
        while (!conv_start && waited < 20) begin
            @(negedge clk); waited++;
        end
        check(conv_start && conv_slot == 4'd0, "R10 grant slot 0", int'(conv_slot), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!busy || conv_start) bad++;
        end
        check(bad == 0, "R10 busy held, no grant while busy", bad, 0);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check(busy == 1'b0, "R10 done clears busy", int'(busy), 0);
        expect_next(4, '0, "R10 next grant after done");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_round_robin();
        t_split();
        t_trigger();
        t_irq();
        t_absorb_power();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule